// File: doc/BRIEF.md
# Reset Cause and Low-Speed Oscillator Status Register

This block is a single 32-bit memory-mapped register. It records which reset sources have fired since software last wiped the record. It also holds the enable for a low-speed oscillator and reports back when that oscillator counts as ready. Seven one-cycle event inputs set sticky cause flags. A write that sets the remove-flags bit clears all of the flags in one step.

The register has two reset domains. The power reset initialises everything. The system reset re-initialises the bus port and the oscillator fields but keeps the cause flags, so software can find out after a system reset why it happened. The oscillator ready flag is produced by a counter in the oscillator clock domain. The enable is synchronised into that domain, and the ready flag is synchronised back into the bus domain.

The bus side uses a request/acknowledge handshake. The master raises `bus_req` and holds every bus input stable until it sees `bus_ack` high. The access completes on the clock edge where both are high. `bus_ack` is back-pressure: when the master keeps `bus_req` high straight after an acknowledged access, the port holds `bus_ack` low for `WAIT_STATES` cycles (0 to 3). An access that follows at least one idle cycle is acknowledged in the cycle it is requested.

Top module: `rstcause_clkstat_reg`

## Requirements
- R1: A one-cycle pulse on a bit of `cause_ev` sets the matching sticky flag, and the flag stays set until it is cleared. The mapping is: `cause_ev[6]` to bit 31 (low-power), `[5]` to bit 30 (window watchdog), `[4]` to bit 29 (independent watchdog), `[3]` to bit 28 (software), `[2]` to bit 27 (power-on), `[1]` to bit 26 (pin), `[0]` to bit 25 (brown-out).
- R2: An accepted write with `bus_be[3]` high and data bit 24 set clears all seven cause flags. Bit 24 always reads 0.
- R3: Writes to bits 31..25 have no effect on the flags.
- R4: After a power reset (`por_n` low), the register reads 0x0E000000: the power-on, pin and brown-out flags are set and everything else is 0.
- R5: A system reset (`sys_rst_n` low) returns the oscillator enable and ready to 0 and leaves the cause flags unchanged.
- R6: If a cause event and a remove-flags write are accepted in the same cycle, the flag of that event stays set and all other flags are cleared.
- R7: A write changes only the byte lanes whose `bus_be` bit is high. The enable (bit 0) needs `bus_be[0]`, and the remove-flags action needs `bus_be[3]`.
- R8: Bits 23..2 always read 0, and writes to them are ignored.
- R9: Bit 0 is the read/write oscillator enable, also driven on `osc_en`. While the enable is set, the ready flag (bit 1, read-only) rises after `START_CYC` oscillator cycles, counted from when the enable is seen in the oscillator domain. It is 0 before that.
- R10: After the enable is cleared, the ready flag falls after `STOP_CYC` (default 6) oscillator cycles. It stays 1 until then.
- R11: An access requested after an idle cycle is acknowledged in the same cycle. An access requested immediately after an acknowledged one waits `WAIT_STATES` cycles before its acknowledge.
- R12: `bus_rdata` in the acknowledge cycle equals the current register value, including after wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, asynchronous, active low |
| osc_clk | input | 1 | Low-speed oscillator clock |
| cause_ev | input | 7 | One-cycle reset cause events (mapping in R1) |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables, bit n covers data bits 8n+7..8n |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completes on this cycle's edge |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| osc_en | output | 1 | Enable to the low-speed oscillator |

## Verification
A cause event and a remove-flags write can be accepted in the same cycle. The bench provokes this by raising an event pulse on the same cycle as an isolated clear write, which is acknowledged in the cycle it is requested. It judges the result by reading back the register: exactly that event's flag must remain set and every other flag must be 0. The table-driven part also interleaves lone events, lone clears and ignored flag writes, so that stickiness is checked against a running expected value.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;
  localparam int REG_W      = 32;
  localparam int N_CAUSE    = 7;
  localparam int CAUSE_LO   = 25;
  localparam int CAUSE_HI   = CAUSE_LO + N_CAUSE - 1;
  localparam int WIPE_BIT   = 24;
  localparam int EN_BIT     = 0;
  localparam int RDY_BIT    = 1;
  localparam int N_LANES    = REG_W / 8;
  localparam logic [N_CAUSE-1:0] CAUSE_POR_VAL = 7'b0000111;

  typedef enum logic [0:0] {BP_IDLE, BP_WAIT} bp_state_t;
endpackage

// File: rtl/rcs_sync.sv
`timescale 1ns/1ps
module rcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rcs_cause_flags.sv
`timescale 1ns/1ps
module rcs_cause_flags
  import rcs_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic [N_CAUSE-1:0] ev,
  input  logic               wipe,
  output logic [N_CAUSE-1:0] flags
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    flags <= CAUSE_POR_VAL;
    else if (wipe) flags <= ev;
    else           flags <= flags | ev;
  end

  a_r1_sticky: assert property (@(posedge clk) disable iff (!por_n)
    !wipe |=> ((flags & $past(flags)) == $past(flags)));
  a_r2_wipe_all: assert property (@(posedge clk) disable iff (!por_n)
    (wipe && ev == '0) |=> (flags == '0));
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!por_n)
    (wipe && ev != '0) |=> ((flags & $past(ev)) == $past(ev)));
endmodule

// File: rtl/rcs_bus_port.sv
`timescale 1ns/1ps
module rcs_bus_port
  import rcs_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack
);
  localparam int CW = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  generate
    if (WAIT_STATES == 0) begin : g_nowait
      assign ack = req && live;
    end else begin : g_wait
      bp_state_t      st;
      logic [CW-1:0]  cnt;
      logic           prev_ack;

      always_comb begin
        ack = 1'b0;
        if (req && live) begin
          if (st == BP_IDLE) ack = !prev_ack;
          else               ack = (cnt == '0);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st       <= BP_IDLE;
          cnt      <= '0;
          prev_ack <= 1'b0;
        end else begin
          prev_ack <= ack;
          case (st)
            BP_IDLE: if (req && prev_ack) begin
              st  <= BP_WAIT;
              cnt <= CW'(WAIT_STATES - 1);
            end
            default: begin
              if (!req || cnt == '0) st <= BP_IDLE;
              else                   cnt <= cnt - 1'b1;
            end
          endcase
        end
      end

      a_r11_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    end
  endgenerate
endmodule

// File: rtl/rcs_osc_ready.sv
`timescale 1ns/1ps
module rcs_osc_ready #(
  parameter int START_CYC   = 8,
  parameter int STOP_CYC    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic osc_clk,
  input  logic rst_n,
  input  logic en,
  output logic rdy
);
  localparam int CNT_TOP = (START_CYC > STOP_CYC) ? START_CYC : STOP_CYC;
  localparam int CW      = $clog2(CNT_TOP + 1);
  localparam logic [CW-1:0] START_LAST = CW'(START_CYC - 1);
  localparam logic [CW-1:0] STOP_LAST  = CW'(STOP_CYC - 1);

  logic          en_s;
  logic          rdy_o;
  logic [CW-1:0] cnt;
  logic          moving;
  logic          done;

  rcs_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(osc_clk), .rst_n(rst_n), .d(en), .q(en_s));

  assign moving = en_s ^ rdy_o;
  assign done   = en_s ? (cnt == START_LAST) : (cnt == STOP_LAST);

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rdy_o <= 1'b0;
    end else if (!moving) begin
      cnt <= '0;
    end else if (done) begin
      cnt   <= '0;
      rdy_o <= en_s;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  rcs_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(rdy_o), .q(rdy));

  a_r9_hold_on: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (en_s && rdy_o) |=> rdy_o);
  a_r10_hold_off: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (!en_s && !rdy_o) |=> !rdy_o);
  a_r10_no_early_drop: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (rdy_o && !en_s && cnt != STOP_LAST) |=> rdy_o);
  a_r9_no_early_rise: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (!rdy_o && en_s && cnt != START_LAST) |=> !rdy_o);
endmodule

// File: rtl/rstcause_clkstat_reg.sv
`timescale 1ns/1ps
module rstcause_clkstat_reg
  import rcs_pkg::*;
#(
  parameter int START_CYC   = 8,
  parameter int STOP_CYC    = 6,
  parameter int WAIT_STATES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst_n,
  input  logic               osc_clk,
  input  logic [N_CAUSE-1:0] cause_ev,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [N_LANES-1:0] bus_be,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic               bus_ack,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               osc_en
);
  logic               sys_n;
  logic               wr_acc;
  logic               wipe;
  logic [N_CAUSE-1:0] flags;
  logic               en_q;
  logic               rdy;

  assign sys_n = por_n & sys_rst_n;

  rcs_bus_port #(.WAIT_STATES(WAIT_STATES)) u_port (
    .clk(clk), .rst_n(sys_n), .req(bus_req), .ack(bus_ack));

  assign wr_acc = bus_ack && bus_we;
  assign wipe   = wr_acc && bus_be[WIPE_BIT/8] && bus_wdata[WIPE_BIT];

  rcs_cause_flags u_flags (
    .clk(clk), .por_n(por_n), .ev(cause_ev), .wipe(wipe), .flags(flags));

  always_ff @(posedge clk or negedge sys_n) begin
    if (!sys_n)                         en_q <= 1'b0;
    else if (wr_acc && bus_be[EN_BIT/8]) en_q <= bus_wdata[EN_BIT];
  end
  assign osc_en = en_q;

  rcs_osc_ready #(
    .START_CYC(START_CYC), .STOP_CYC(STOP_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_osc (
    .clk(clk), .osc_clk(osc_clk), .rst_n(sys_n), .en(en_q), .rdy(rdy));

  always_comb begin
    bus_rdata = '0;
    bus_rdata[CAUSE_HI:CAUSE_LO] = flags;
    bus_rdata[RDY_BIT] = rdy;
    bus_rdata[EN_BIT]  = en_q;
  end

  a_r5_flags_survive: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && cause_ev == '0) |=> $stable(flags));
  a_r7_lane_gate: assert property (@(posedge clk) disable iff (!sys_n)
    (wr_acc && !bus_be[EN_BIT/8]) |=> $stable(en_q));
  a_r3_flag_write_inert: assert property (@(posedge clk) disable iff (!por_n)
    (wr_acc && !bus_wdata[WIPE_BIT] && cause_ev == '0) |=> $stable(flags));
endmodule

// File: tb/sim_rstcause_clkstat_reg.sv
`timescale 1ns/1ps
module sim_rstcause_clkstat_reg;
  localparam int START_CYC = 8;
  localparam int STOP_CYC  = 6;
  localparam int WAITS     = 2;

  logic        clk = 1'b0, osc_clk = 1'b0;
  logic        por_n = 1'b0, sys_rst_n = 1'b1;
  logic [6:0]  cause_ev = '0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        osc_en;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always #12 osc_clk = ~osc_clk;

  rstcause_clkstat_reg #(.START_CYC(START_CYC), .STOP_CYC(STOP_CYC),
    .WAIT_STATES(WAITS), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .osc_clk(osc_clk),
    .cause_ev(cause_ev), .bus_req(bus_req), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .osc_en(osc_en));

  // entry: ev[15:9], clear[8], flag write[7], expected flags[6:0]
  localparam logic [15:0] VEC [13] = '{
    16'b0000000_1_0_0000000, 16'b1000000_0_0_1000000,
    16'b0100000_0_0_1100000, 16'b0000000_0_1_1100000,
    16'b0010000_0_0_1110000, 16'b0001000_1_0_0001000,
    16'b0000100_0_0_0001100, 16'b0000010_0_0_0001110,
    16'b0000001_0_0_0001111, 16'b0000000_1_0_0000000,
    16'b1111111_0_0_1111111, 16'b0000001_1_0_0000001,
    16'b0000000_0_1_0000001
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_ack();
    #1;
    while (!bus_ack) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic bus_write(input logic [31:0] d, input logic [3:0] be, input logic [6:0] ev);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_be = be; bus_wdata = d; cause_ev = ev;
    wait_ack();
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; cause_ev = '0;
    @(negedge clk);
  endtask

  task automatic bus_read(output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_be = 4'hF;
    wait_ack();
    d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ev(input logic [6:0] ev);
    @(negedge clk);
    cause_ev = ev;
    @(negedge clk);
    cause_ev = '0;
  endtask

  initial begin
    logic [31:0] rd;
    int n;
    repeat (4) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 / R8: power reset value
    bus_read(rd);
    check("R4 power reset value", rd, 32'h0E000000);
    check("R8 reserved zero", {8'h0, rd[23:2], 2'b0}, 32'h0);
    check("R9 enable port after reset", {31'h0, osc_en}, 32'h0);

    // R1 R2 R3 R6: vector table
    for (int i = 0; i < 13; i++) begin
      logic [6:0] ev;
      logic [6:0] ex;
      string tag;
      ev = VEC[i][15:9];
      ex = VEC[i][6:0];
      if (VEC[i][8])      bus_write(32'h01000000, 4'b1000, ev);
      else if (VEC[i][7]) bus_write(32'hFE000000, 4'b1000, ev);
      else                pulse_ev(ev);
      if (VEC[i][8] && ev != 0) tag = "R6 event beats clear";
      else if (VEC[i][8])       tag = "R2 clear all";
      else if (VEC[i][7])       tag = "R3 flag write ignored";
      else                      tag = "R1 sticky set";
      bus_read(rd);
      check(tag, rd, {ex, 25'h0});
    end

    // R7 / R8: lane 3 disabled so bit 24 does not clear; reserved ignore ones
    bus_write(32'hFFFFFFFF, 4'b0001, 7'h0);
    bus_read(rd);
    check("R7 lane0 write, no clear", rd, 32'h02000001);
    check("R9 not ready yet", {31'h0, rd[1]}, 32'h0);
    bus_write(32'h00000000, 4'b1110, 7'h0);
    check("R7 enable kept without lane0", {31'h0, osc_en}, 32'h1);

    // R9: ready rises
    repeat (START_CYC + 6) @(posedge osc_clk);
    bus_read(rd);
    check("R9 ready after start", rd, 32'h02000003);

    // R10: ready falls after stop count
    bus_write(32'h0, 4'b0001, 7'h0);
    repeat (3) @(posedge osc_clk);
    bus_read(rd);
    check("R10 ready held after disable", rd, 32'h02000002);
    repeat (STOP_CYC + 6) @(posedge osc_clk);
    bus_read(rd);
    check("R10 ready dropped", rd, 32'h02000000);

    // R11 / R12: back-to-back reads
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_be = 4'hF;
    #1;
    check("R11 isolated ack same cycle", {31'h0, bus_ack}, 32'h1);
    check("R12 first read data", bus_rdata, 32'h02000000);
    @(negedge clk);
    n = 0;
    #1;
    while (!bus_ack && n < 10) begin
      n++;
      @(negedge clk);
      #1;
    end
    check("R11 back-to-back wait count", n, WAITS);
    check("R12 data after wait", bus_rdata, 32'h02000000);
    @(negedge clk);
    bus_req = 1'b0;
    @(negedge clk);

    // R5: system reset keeps flags, clears enable
    bus_write(32'h1, 4'b0001, 7'h0);
    pulse_ev(7'b0100000);
    @(negedge clk);
    sys_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 enable cleared", {31'h0, osc_en}, 32'h0);
    bus_read(rd);
    check("R5 flags kept", rd, 32'h42000000);

    // R4: power reset again
    @(negedge clk);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(rd);
    check("R4 second power reset", rd, 32'h0E000000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule